// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a processor's store port and a memory bus controller. It takes byte-enabled stores and parks them in line-sized entries. Each entry covers one aligned line of `LINE_BYTES` bytes. The entries wait there until the bus side takes them as full-line writes with a byte mask. The buffer is always on and every store passes through it.

Whether a store may fold into an entry that is already queued is decided by two things together: a global enable pin and a region attribute that comes with the store. When merging is allowed, a store can join any queued entry for the same line, except the entry currently offered on the bus. The store then reaches memory ahead of stores that were issued between the two. When merging is not allowed, every store takes a new entry, and entries leave strictly oldest first.

A store marked strongly ordered (non-cacheable and non-bufferable) is accepted and then blocks the store port until its own bus write has been taken. A drain request stops intake and reports when the buffer is empty.

Both data interfaces are valid/ready:
- **Store port:** a store transfers on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` may depend on the store currently presented, because it can merge even when the buffer is full.
- **Bus port:** once `bus_valid` is high, the write it carries must be held unchanged until `bus_ready` accepts it.

Top module: `store_coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: `bus_valid` is 0, `st_ready` is 1 and `drain_done` is 0 while `drain_req` is 0.
- R2: Entries are written to the bus oldest first. Each transfer carries the line address, the byte mask and the line data. Byte lane k is `data[8k+7:8k]` and is enabled by mask bit k. Lanes outside the mask read as zero.
- R3: With `coalesce_en` at 0, every accepted store takes a new entry, whatever `st_region_merge` says.
- R4: With `coalesce_en` and `st_region_merge` both at 1, a store to the line of a queued entry that is not on the bus merges into it. The merge ORs the byte enables into the entry's mask, overwrites the enabled data bytes and takes no new entry.
- R5: With `coalesce_en` at 1 but `st_region_merge` at 0, a store takes a new entry even when a matching mergeable entry exists.
- R6: The entry currently offered on the bus accepts no merge. A store to its line takes a new entry.
- R7: When all `N_ENT` entries are used, `st_ready` is 0 for a store that cannot merge. It is 1 for a store that can merge.
- R8: After a store with `st_strong` at 1 is accepted, `st_ready` stays 0 until that store's bus write has been accepted. A strong store never merges into another entry, and no store merges into it.
- R9: While `drain_req` is 1, `st_ready` is 0. `drain_done` is 1 exactly when `drain_req` is 1 and no entry is pending (`bus_valid` is 0).
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_addr`, `bus_mask` and `bus_data` hold their values on the next cycle.
- R11: `bus_addr` is the store's line address with its low log2(`LINE_BYTES`) bits forced to zero. The store address's offset bits play no part in selecting the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coalesce_en | input | 1 | Global merge enable |
| drain_req | input | 1 | Request to empty the buffer; blocks intake |
| drain_done | output | 1 | High while a drain is requested and the buffer is empty |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store byte address (line taken from upper bits) |
| st_be | input | LINE_BYTES | Byte enables, one per line lane |
| st_data | input | 8*LINE_BYTES | Store data, lane-aligned within the line |
| st_region_merge | input | 1 | Region attribute: merging allowed for this store |
| st_strong | input | 1 | Region is non-cacheable and non-bufferable |
| bus_valid | output | 1 | A line write is offered to the bus |
| bus_ready | input | 1 | Bus accepts the offered write |
| bus_addr | output | ADDR_W | Aligned line address |
| bus_mask | output | LINE_BYTES | Byte mask of the line write |
| bus_data | output | 8*LINE_BYTES | Line write data |

## Verification
The cycle-level assertions cover the following on every cycle:
- the bus-side hold rule;
- the stall after a strongly ordered store is accepted;
- the blocking of intake during a drain, and `drain_done` only ever appearing with an empty bus side;
- the refusal of a non-merging store into a full buffer.

Which entry a store lands in can only be shown by the bench's scenarios. So can the merged masks and data, the order in which lines leave, the head-entry exclusion, and the interaction of the global and per-region merge controls. The bench shows these by holding the bus back, filling the buffer and comparing each line write against values derived from the requirements.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2
  } st_action_e;
endpackage

// File: rtl/cwb_order.sv
module cwb_order #(
  parameter int N_ENT = 8,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W:0]   count,
  output logic             full,
  output logic             empty
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign full  = (count == (IDX_W+1)'(N_ENT));
  assign empty = (count == '0);
endmodule

// File: rtl/cwb_match.sv
module cwb_match #(
  parameter int N_ENT = 8,
  parameter int TAG_W = 28,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]            cand,
  input  logic [N_ENT-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            probe,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [N_ENT-1:0] eq;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign eq[i] = cand[i] && (tags[i] == probe);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/cwb_lane_mask.sv
module cwb_lane_mask #(
  parameter int LINE_BYTES = 16
) (
  input  logic [LINE_BYTES-1:0]   be,
  output logic [8*LINE_BYTES-1:0] bits
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign bits[8*b +: 8] = {8{be[b]}};
  end
endmodule

// File: rtl/store_coalesce_wbuf.sv
module store_coalesce_wbuf
  import cwb_pkg::*;
#(
  parameter int N_ENT      = 8,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    coalesce_en,
  input  logic                    drain_req,
  output logic                    drain_done,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [LINE_BYTES-1:0]   st_be,
  input  logic [8*LINE_BYTES-1:0] st_data,
  input  logic                    st_region_merge,
  input  logic                    st_strong,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [LINE_BYTES-1:0]   bus_mask,
  output logic [8*LINE_BYTES-1:0] bus_data
);
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int DATA_W = 8 * LINE_BYTES;

  // Entry storage
  logic [N_ENT-1:0]             e_vld, e_mrg, e_sync;
  logic [N_ENT-1:0][TAG_W-1:0]  e_tag;
  logic [N_ENT-1:0][LINE_BYTES-1:0] e_mask;
  logic [N_ENT-1:0][DATA_W-1:0] e_data;

  logic [IDX_W-1:0] head, tail, hit_idx;
  logic [IDX_W:0]   count;
  logic             full, empty, hit;
  logic             push, pop, merge_req, merge_ok, sync_pend, accept;
  logic [N_ENT-1:0] busy_vec, cand;
  logic [TAG_W-1:0] st_tag;
  logic [DATA_W-1:0] be_bits;
  logic [OFS_W-1:0] unused_ofs;
  st_action_e       act;

  assign st_tag     = st_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = st_addr[OFS_W-1:0];

  cwb_lane_mask #(.LINE_BYTES(LINE_BYTES)) u_lanes (
    .be   (st_be),
    .bits (be_bits)
  );

  // The head entry is on the bus whenever the buffer is not empty
  always_comb begin
    busy_vec = '0;
    if (!empty) busy_vec[head] = 1'b1;
  end

  assign cand = e_vld & e_mrg & ~busy_vec;

  cwb_match #(.N_ENT(N_ENT), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .cand    (cand),
    .tags    (e_tag),
    .probe   (st_tag),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  assign merge_req = coalesce_en && st_region_merge && !st_strong;
  assign merge_ok  = merge_req && hit;
  assign sync_pend = |(e_vld & e_sync);
  assign st_ready  = !drain_req && !sync_pend && (merge_ok || !full);
  assign accept    = st_valid && st_ready;

  always_comb begin
    if (!accept)       act = ACT_IDLE;
    else if (merge_ok) act = ACT_MERGE;
    else               act = ACT_ALLOC;
  end

  assign push = (act == ACT_ALLOC);
  assign pop  = bus_valid && bus_ready;

  cwb_order #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .head  (head),
    .tail  (tail),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_mrg  <= '0;
      e_sync <= '0;
      e_tag  <= '0;
      e_mask <= '0;
      e_data <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (push && tail == IDX_W'(i)) begin
          e_vld[i]  <= 1'b1;
          e_mrg[i]  <= merge_req;
          e_sync[i] <= st_strong;
          e_tag[i]  <= st_tag;
          e_mask[i] <= st_be;
          e_data[i] <= st_data & be_bits;
        end else if (pop && head == IDX_W'(i)) begin
          e_vld[i]  <= 1'b0;
        end
        if (act == ACT_MERGE && hit_idx == IDX_W'(i)) begin
          e_mask[i] <= e_mask[i] | st_be;
          e_data[i] <= (e_data[i] & ~be_bits) | (st_data & be_bits);
        end
      end
    end
  end

  assign bus_valid  = !empty;
  assign bus_addr   = {e_tag[head], {OFS_W{1'b0}}};
  assign bus_mask   = e_mask[head];
  assign bus_data   = e_data[head];
  assign drain_done = drain_req && empty;
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
  parameter int N_ENT      = 8,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = $clog2(N_ENT)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_valid,
  input logic                    st_ready,
  input logic                    st_strong,
  input logic                    drain_req,
  input logic                    drain_done,
  input logic                    bus_valid,
  input logic                    bus_ready,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [LINE_BYTES-1:0]   bus_mask,
  input logic [8*LINE_BYTES-1:0] bus_data,
  input logic [IDX_W:0]          occ,
  input logic                    mrg_hit
);
  // R10: an offered write is held until taken
  a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_mask) && $stable(bus_data));

  // R8: a strongly ordered store stalls the port once accepted
  a_r8_strong_stall: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_strong |=> !st_ready);

  // R9: no intake during a drain
  a_r9_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !st_ready);

  // R9: done only with nothing offered to the bus
  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !bus_valid);

  // R7: a full buffer refuses stores that cannot merge
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (IDX_W+1)'(N_ENT)) && !mrg_hit |-> !st_ready);

  // R7: occupancy never exceeds the entry count
  a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (IDX_W+1)'(N_ENT));
endmodule

bind store_coalesce_wbuf cwb_checker #(
  .N_ENT(N_ENT), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_strong  (st_strong),
  .drain_req  (drain_req),
  .drain_done (drain_done),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_addr   (bus_addr),
  .bus_mask   (bus_mask),
  .bus_data   (bus_data),
  .occ        (count),
  .mrg_hit    (merge_ok)
);

// File: tb/store_coalesce_wbuf_tb_top.sv
`timescale 1ns/1ps
module store_coalesce_wbuf_tb_top;
  localparam int NE = 8;
  localparam int LB = 16;
  localparam int AW = 32;
  localparam int DW = 8 * LB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          coalesce_en = 1'b0, drain_req = 1'b0, drain_done;
  logic          st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [LB-1:0] st_be = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_region_merge = 1'b0, st_strong = 1'b0;
  logic          bus_valid, bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [LB-1:0] bus_mask;
  logic [DW-1:0] bus_data;

  store_coalesce_wbuf #(.N_ENT(NE), .LINE_BYTES(LB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .coalesce_en(coalesce_en), .drain_req(drain_req),
    .drain_done(drain_done), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
    .st_region_merge(st_region_merge), .st_strong(st_strong),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_mask(bus_mask), .bus_data(bus_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // Stimulus table (coalescing on, bus held back): address, enables, byte value, region merge
  localparam logic [31:0] S_ADR [6] = '{32'h104, 32'h10C, 32'h208, 32'h100, 32'h20F, 32'h204};
  localparam logic [15:0] S_BE  [6] = '{16'h000F, 16'h00F0, 16'h0F00, 16'h00FF, 16'hF000, 16'h00F0};
  localparam logic [7:0]  S_VAL [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
  localparam logic        S_MRG [6] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  // Expected bus writes in order
  localparam logic [31:0]  W_ADR [4] = '{32'h100, 32'h100, 32'h200, 32'h200};
  localparam logic [15:0]  W_MSK [4] = '{16'h000F, 16'h00FF, 16'h0FF0, 16'hF000};
  localparam logic [127:0] W_DAT [4] = '{
    128'h0000_0000_0000_0000_0000_0000_1111_1111,
    128'h0000_0000_0000_0000_4444_4444_4444_4444,
    128'h0000_0000_3333_3333_6666_6666_0000_0000,
    128'h5555_5555_0000_0000_0000_0000_0000_0000};

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [15:0] be, input logic [7:0] v,
                     input bit m, input bit s);
    @(negedge clk);
    st_addr = a; st_be = be; st_data = {LB{v}}; st_region_merge = m; st_strong = s;
    st_valid = 1'b1;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 st_valid = 1'b0;
  endtask

  task automatic take(input logic [31:0] a, input logic [15:0] m, input logic [127:0] d,
                      input string req);
    @(negedge clk);
    check(bus_valid == 1'b1, {req, " valid"}, 128'(bus_valid), 128'(1));
    check(bus_addr == a, {req, " addr"}, 128'(bus_addr), 128'(a));
    check(bus_mask == m, {req, " mask"}, 128'(bus_mask), 128'(m));
    check(bus_data == d, {req, " data"}, bus_data, d);
    bus_ready = 1'b1;
    @(posedge clk); #1 bus_ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0]  a0;
    logic [15:0]  m0;
    logic [127:0] d0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(bus_valid == 1'b0, "R1 bus_valid", 128'(bus_valid), 128'(0));
    check(st_ready == 1'b1, "R1 st_ready", 128'(st_ready), 128'(1));
    check(drain_done == 1'b0, "R1 drain_done", 128'(drain_done), 128'(0));

    // Table: R4 merge, R5 region off, R6 head excluded, R11 alignment, R2 order
    coalesce_en = 1'b1;
    for (int k = 0; k < 6; k++) put(S_ADR[k], S_BE[k], S_VAL[k], S_MRG[k], 1'b0);
    @(negedge clk);
    a0 = bus_addr; m0 = bus_mask; d0 = bus_data;
    repeat (3) @(negedge clk);
    check(bus_addr == a0 && bus_mask == m0 && bus_data == d0, "R10 hold while stalled",
          {bus_addr, bus_mask, 80'(0)}, {a0, m0, 80'(0)});
    for (int k = 0; k < 4; k++) take(W_ADR[k], W_MSK[k], W_DAT[k], "R2 R4 R5 R6 R11 table");

    // R3: global enable off, region attribute set, same line -> separate entries
    coalesce_en = 1'b0;
    put(32'h2000, 16'h0001, 8'h01, 1'b1, 1'b0);
    put(32'h2001, 16'h0002, 8'h02, 1'b1, 1'b0);
    put(32'h2002, 16'h0004, 8'h03, 1'b1, 1'b0);
    take(32'h2000, 16'h0001, 128'h01, "R3 first");
    take(32'h2000, 16'h0002, 128'h0200, "R3 second");
    take(32'h2000, 16'h0004, 128'h030000, "R3 third");

    // R7: fill all entries, then refuse a new line but accept a merge
    coalesce_en = 1'b1;
    for (int i = 0; i < NE; i++) put(32'h1000 + 32'(16 * i), 16'h0001, 8'(i + 1), 1'b1, 1'b0);
    @(negedge clk);
    st_addr = 32'h1000 + 32'(16 * 9); st_be = 16'h0001; st_data = {LB{8'hEE}};
    st_region_merge = 1'b1; st_strong = 1'b0; st_valid = 1'b1;
    #1 check(st_ready == 1'b0, "R7 full refuses new line", 128'(st_ready), 128'(0));
    st_addr = 32'h1030; st_be = 16'h0002; st_data = {LB{8'hAA}};
    #1 check(st_ready == 1'b1, "R7 full accepts merge", 128'(st_ready), 128'(1));
    @(posedge clk); #1 st_valid = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (i == 3) take(32'h1030, 16'h0003, 128'hAA04, "R7 merged entry");
      else take(32'h1000 + 32'(16 * i), 16'h0001, 128'(i + 1), "R7 drain order");
    end

    // R8: strongly ordered store stalls until its bus write is taken
    put(32'h3000, 16'h0001, 8'h01, 1'b1, 1'b0);
    put(32'h3010, 16'h000F, 8'h77, 1'b1, 1'b1);
    @(negedge clk);
    st_addr = 32'h3010; st_be = 16'h00F0; st_data = {LB{8'h77}};
    st_region_merge = 1'b1; st_strong = 1'b0; st_valid = 1'b1;
    #1 check(st_ready == 1'b0, "R8 stall after strong", 128'(st_ready), 128'(0));
    take(32'h3000, 16'h0001, 128'h01, "R8 older first");
    @(negedge clk); #1
    check(st_ready == 1'b0, "R8 stall holds", 128'(st_ready), 128'(0));
    take(32'h3010, 16'h000F, 128'h7777_7777, "R8 strong write");
    @(negedge clk); #1
    check(st_ready == 1'b1, "R8 release", 128'(st_ready), 128'(1));
    @(posedge clk); #1 st_valid = 1'b0;
    take(32'h3010, 16'h00F0, 128'h7777_7777_0000_0000, "R8 no merge into strong");

    // R9: drain blocks intake and reports empty
    put(32'h4000, 16'h0001, 8'h09, 1'b1, 1'b0);
    @(negedge clk);
    drain_req = 1'b1;
    st_addr = 32'h4100; st_be = 16'h0001; st_valid = 1'b1;
    #1 check(st_ready == 1'b0, "R9 intake blocked", 128'(st_ready), 128'(0));
    check(drain_done == 1'b0, "R9 not done yet", 128'(drain_done), 128'(0));
    st_valid = 1'b0;
    take(32'h4000, 16'h0001, 128'h09, "R9 drained write");
    @(negedge clk); #1
    check(drain_done == 1'b1, "R9 done", 128'(drain_done), 128'(1));
    check(bus_valid == 1'b0, "R9 empty", 128'(bus_valid), 128'(0));
    drain_req = 1'b0;
    #1 check(drain_done == 1'b0, "R9 done drops", 128'(drain_done), 128'(0));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule